// File: doc/BRIEF.md
# Register Save/Restore Burst Sequencer

This block turns a single "save all registers" or "restore all registers" instruction into a fixed, tick-timed series of control strobes. A microcode word is effectively fixed for every tick. On a save burst, seven general registers are read one at a time and written to descending stack cells. Each cell is cleared one tick before its value arrives. The stack pointer is stepped down once per stored register. On a restore burst, the same seven registers are loaded back from ascending stack cells in the opposite order. The stack pointer is stepped up once per loaded register.

The sequencer sits between the instruction decoder, the register file and the data RAM. The decoder issues a one-cycle start pulse with a direction select and the current stack pointer. The sequencer then owns the register-file read select, the register write-back port and the RAM address, data, write, clear and read strobes. It also issues the fetch and instruction-pointer increment strobes part-way through the burst, so the next instruction is already on its way when the burst ends. Register encodings are 0 to 7, with slot 4 being the stack pointer itself, which is never saved or restored.

Top module: `stack_burst_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every strobe is low, busy is low, and the address, select and data outputs are zero.
- R2: A start pulse sampled while idle is accepted. Busy is then high for exactly 14 ticks for a save (pop select 0) and 9 ticks for a restore (pop select 1), starting in the cycle after the start pulse, and it falls after that.
- R3: On a save, the register read select is driven on ticks 2, 4, 6, 8, 10, 12 and 14 with the codes 0, 1, 2, 3, 5, 6, 7 in that order. On those ticks the RAM write data equals the register read data, and code 4 is never selected.
- R4: On a save, the RAM write strobe is high on every tick from 1 to 14. The clear strobe is high on ticks 1, 3, ..., 13 only, with the write data zero on those ticks.
- R5: On a save with start stack pointer S, ticks 2k-1 and 2k address cell S-k (k = 1..7, modulo 2^ADDR_W). The stack-pointer decrement strobe is high on the even ticks 2..14, one tick after the clear of the same cell.
- R6: The fetch and instruction-pointer increment strobes are both high for exactly one tick: tick 9 of a save and tick 4 of a restore.
- R7: On a restore with start stack pointer S, ticks 1..7 have the RAM read strobe, the register write strobe and the stack-pointer increment strobe high. The address is S+t-1, the write-back select follows the codes 7, 6, 5, 3, 2, 1, 0, and the write-back data equals the RAM read data. Ticks 8 and 9 carry no strobe.
- R8: A start pulse received while busy is ignored. The running burst continues unchanged and ends at its normal length.
- R9: The stack-pointer input is sampled only when a start is accepted. Later changes to it do not move the addresses of the running burst.
- R10: Asserting reset in the middle of a burst forces every output low at once. After release, the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | One-cycle request to begin a burst |
| pop_i | input | 1 | Burst direction: 0 save, 1 restore |
| sp_i | input | ADDR_W | Current stack pointer, sampled on an accepted start |
| rf_rdata_i | input | DATA_W | Register-file read data for rf_rsel_o |
| mem_rdata_i | input | DATA_W | RAM read data for mem_addr_o |
| busy_o | output | 1 | Burst in progress |
| rf_rsel_o | output | SEL_W | Register read select |
| rf_we_o | output | 1 | Register write-back strobe |
| rf_wsel_o | output | SEL_W | Register write-back select |
| rf_wdata_o | output | DATA_W | Register write-back data |
| mem_addr_o | output | ADDR_W | RAM cell address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_we_o | output | 1 | RAM write strobe |
| mem_clr_o | output | 1 | RAM cell clear strobe |
| mem_re_o | output | 1 | RAM read strobe |
| sp_dec_o | output | 1 | Stack-pointer decrement strobe |
| sp_inc_o | output | 1 | Stack-pointer increment strobe |
| fetch_o | output | 1 | Fetch-next-instruction strobe |
| pc_inc_o | output | 1 | Instruction-pointer increment strobe |

## Verification
The overlapped fetch is the function most likely to collide with the data path. On a save it lands on a clear tick (tick 9). On a restore it lands on a register load (tick 4). The bench walks both bursts tick by tick and compares the full strobe word on every tick, so a fetch that displaces or suppresses the RAM or register strobe sharing its cycle is caught. A second collision is a new start pulse arriving during a burst. The bench raises start with the opposite direction at a middle tick and at the final tick, changes the stack-pointer input at the same time, and judges the result by the unchanged strobe word, the addresses and busy falling on schedule.

// File: rtl/stack_burst_pkg.sv
package stack_burst_pkg;

  typedef enum logic {
    MODE_SAVE    = 1'b0,
    MODE_RESTORE = 1'b1
  } burst_mode_e;

  // Map a burst slot (0..n-1) onto a register code, stepping over the
  // stack-pointer code so that it is never part of a burst.
  function automatic int unsigned slot_to_reg(input int unsigned slot,
                                              input int unsigned skip);
    return (slot < skip) ? slot : slot + 1;
  endfunction

endpackage

// File: rtl/stack_burst_ctrl.sv
module stack_burst_ctrl
  import stack_burst_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int TICK_W   = 4,
  parameter int SAVE_LEN = 14,
  parameter int REST_LEN = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic [TICK_W-1:0] tick_o,
  output burst_mode_e       mode_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              busy_o
);

  logic [TICK_W-1:0] tick_q, tick_d, cur_len;
  burst_mode_e       mode_q, mode_d;
  logic [ADDR_W-1:0] base_q;
  logic              accept;

  assign cur_len = (mode_q == MODE_RESTORE) ? TICK_W'(REST_LEN) : TICK_W'(SAVE_LEN);
  assign accept  = (tick_q == '0) && start_i;

  always_comb begin
    tick_d = tick_q;
    mode_d = mode_q;
    if (accept) begin
      tick_d = TICK_W'(1);
      mode_d = pop_i ? MODE_RESTORE : MODE_SAVE;
    end else if (tick_q != '0) begin
      tick_d = (tick_q == cur_len) ? '0 : tick_q + TICK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      mode_q <= MODE_SAVE;
    end else begin
      tick_q <= tick_d;
      mode_q <= mode_d;
    end
  end

  // Datapath register: loaded only on an accepted start, no reset needed.
  always_ff @(posedge clk) begin
    if (accept) base_q <= sp_i;
  end

  assign tick_o = tick_q;
  assign mode_o = mode_q;
  assign base_o = base_q;
  assign busy_o = (tick_q != '0);

  a_r8_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q != '0 && tick_q != cur_len) |=> (tick_q == $past(tick_q) + TICK_W'(1)));

  a_r2_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q != '0 && tick_q == cur_len) |=> (tick_q == '0));

  a_r9_base_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q != '0 && tick_q != cur_len) |=> $stable(base_q));

endmodule

// File: rtl/stack_burst_save.sv
module stack_burst_save
  import stack_burst_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 3,
  parameter int TICK_W    = 4,
  parameter int NREG      = 7,
  parameter int SKIP_IDX  = 4,
  parameter int FETCH_AT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              we_o,
  output logic              clr_o,
  output logic              dec_o,
  output logic [SEL_W-1:0]  rsel_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fetch_o
);

  localparam int LEN = 2 * NREG;

  logic              run, rd_slot;
  logic [ADDR_W-1:0] depth;
  logic [TICK_W-1:0] slot;

  assign run     = active_i && (tick_i != '0) && (tick_i <= TICK_W'(LEN));
  assign rd_slot = run && !tick_i[0];
  // Cell depth below the base: ticks 2k-1 and 2k share depth k.
  assign depth   = (ADDR_W'(tick_i) + ADDR_W'(1)) >> 1;
  assign slot    = TICK_W'(depth) - TICK_W'(1);

  always_comb begin
    we_o    = run;
    clr_o   = run && tick_i[0];
    dec_o   = rd_slot;
    rsel_o  = rd_slot ? SEL_W'(slot_to_reg(int'(slot), SKIP_IDX)) : '0;
    wdata_o = rd_slot ? rf_rdata_i : '0;
    addr_o  = run ? (base_i - depth) : '0;
    fetch_o = run && (tick_i == TICK_W'(FETCH_AT));
  end

  a_r5_addr_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_o && tick_i != TICK_W'(LEN)) |=> (addr_o == $past(addr_o) - ADDR_W'(1)));

  a_r4_clear_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> (we_o && !clr_o && dec_o && addr_o == $past(addr_o)));

  a_r3_skip_sp: assert property (@(posedge clk) disable iff (!rst_n)
    dec_o |-> (rsel_o != SEL_W'(SKIP_IDX)));

endmodule

// File: rtl/stack_burst_restore.sv
module stack_burst_restore
  import stack_burst_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 3,
  parameter int TICK_W    = 4,
  parameter int NREG      = 7,
  parameter int SKIP_IDX  = 4,
  parameter int FETCH_AT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              re_o,
  output logic              inc_o,
  output logic              rf_we_o,
  output logic [SEL_W-1:0]  wsel_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fetch_o
);

  localparam int LEN = NREG + 2;

  logic              run, ld;
  logic [TICK_W-1:0] slot;

  assign run  = active_i && (tick_i != '0) && (tick_i <= TICK_W'(LEN));
  assign ld   = run && (tick_i <= TICK_W'(NREG));
  // Reverse slot order: tick 1 restores the last slot saved.
  assign slot = TICK_W'(NREG) - tick_i;

  always_comb begin
    re_o    = ld;
    inc_o   = ld;
    rf_we_o = ld;
    wsel_o  = ld ? SEL_W'(slot_to_reg(int'(slot), SKIP_IDX)) : '0;
    wdata_o = ld ? mem_rdata_i : '0;
    addr_o  = ld ? (base_i + ADDR_W'(tick_i) - ADDR_W'(1)) : '0;
    fetch_o = run && (tick_i == TICK_W'(FETCH_AT));
  end

  a_r7_addr_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_o && tick_i < TICK_W'(NREG)) |=> (inc_o && addr_o == $past(addr_o) + ADDR_W'(1)));

  a_r7_skip_sp: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (wsel_o != SEL_W'(SKIP_IDX)));

endmodule

// File: rtl/stack_burst_seq.sv
module stack_burst_seq
  import stack_burst_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 3,
  parameter int NREG       = 7,
  parameter int SKIP_IDX   = 4,
  parameter int SAVE_FETCH = 9,
  parameter int REST_FETCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [DATA_W-1:0] rf_rdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic [SEL_W-1:0]  rf_rsel_o,
  output logic              rf_we_o,
  output logic [SEL_W-1:0]  rf_wsel_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_clr_o,
  output logic              mem_re_o,
  output logic              sp_dec_o,
  output logic              sp_inc_o,
  output logic              fetch_o,
  output logic              pc_inc_o
);

  localparam int SAVE_LEN = 2 * NREG;
  localparam int REST_LEN = NREG + 2;
  localparam int MAX_LEN  = (SAVE_LEN > REST_LEN) ? SAVE_LEN : REST_LEN;
  localparam int TICK_W   = $clog2(MAX_LEN + 1);

  logic [TICK_W-1:0] tick;
  burst_mode_e       mode;
  logic [ADDR_W-1:0] base;
  logic              save_act, rest_act;
  logic [ADDR_W-1:0] s_addr, r_addr;
  logic              s_fetch, r_fetch;

  stack_burst_ctrl #(
    .ADDR_W(ADDR_W), .TICK_W(TICK_W), .SAVE_LEN(SAVE_LEN), .REST_LEN(REST_LEN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pop_i(pop_i), .sp_i(sp_i),
    .tick_o(tick), .mode_o(mode), .base_o(base), .busy_o(busy_o)
  );

  assign save_act = (mode == MODE_SAVE);
  assign rest_act = (mode == MODE_RESTORE);

  stack_burst_save #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .TICK_W(TICK_W),
    .NREG(NREG), .SKIP_IDX(SKIP_IDX), .FETCH_AT(SAVE_FETCH)
  ) u_save (
    .clk(clk), .rst_n(rst_n), .active_i(save_act), .tick_i(tick), .base_i(base),
    .rf_rdata_i(rf_rdata_i), .we_o(mem_we_o), .clr_o(mem_clr_o), .dec_o(sp_dec_o),
    .rsel_o(rf_rsel_o), .wdata_o(mem_wdata_o), .addr_o(s_addr), .fetch_o(s_fetch)
  );

  stack_burst_restore #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .TICK_W(TICK_W),
    .NREG(NREG), .SKIP_IDX(SKIP_IDX), .FETCH_AT(REST_FETCH)
  ) u_rest (
    .clk(clk), .rst_n(rst_n), .active_i(rest_act), .tick_i(tick), .base_i(base),
    .mem_rdata_i(mem_rdata_i), .re_o(mem_re_o), .inc_o(sp_inc_o), .rf_we_o(rf_we_o),
    .wsel_o(rf_wsel_o), .wdata_o(rf_wdata_o), .addr_o(r_addr), .fetch_o(r_fetch)
  );

  // Only one microcode half is active at a time; the idle half drives zeros.
  assign mem_addr_o = s_addr | r_addr;
  assign fetch_o    = s_fetch | r_fetch;
  assign pc_inc_o   = s_fetch | r_fetch;

  a_r6_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |=> !fetch_o);

  a_r6_fetch_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> (busy_o && pc_inc_o));

  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !((mem_we_o || sp_dec_o) && (mem_re_o || sp_inc_o)));

endmodule

// File: tb/stack_burst_seq_test.sv
module stack_burst_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, pop_i;
  logic [15:0] sp_i;
  logic [31:0] rf_rdata, mem_rdata;
  logic        busy;
  logic [2:0]  rf_rsel, rf_wsel;
  logic        rf_we;
  logic [31:0] rf_wdata, mem_wdata;
  logic [15:0] mem_addr;
  logic        mem_we, mem_clr, mem_re, sp_dec, sp_inc, fetch, pc_inc;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  // Simple models of the neighbours.
  assign rf_rdata  = {8'hA5, 21'h0, rf_rsel};
  assign mem_rdata = {16'hC0DE, mem_addr};

  stack_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pop_i(pop_i), .sp_i(sp_i),
    .rf_rdata_i(rf_rdata), .mem_rdata_i(mem_rdata), .busy_o(busy),
    .rf_rsel_o(rf_rsel), .rf_we_o(rf_we), .rf_wsel_o(rf_wsel), .rf_wdata_o(rf_wdata),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_clr_o(mem_clr), .mem_re_o(mem_re), .sp_dec_o(sp_dec), .sp_inc_o(sp_inc),
    .fetch_o(fetch), .pc_inc_o(pc_inc)
  );

  // Expected strobe word per tick: {we, clr, dec, inc, re, rfwe, fetch, sel[2:0]}.
  // Entries 0..13 are save ticks 1..14, entries 14..22 restore ticks 1..9.
  localparam logic [9:0] VEC [0:22] = '{
    10'b1100000_000, 10'b1010000_000, 10'b1100000_000, 10'b1010000_001,
    10'b1100000_000, 10'b1010000_010, 10'b1100000_000, 10'b1010000_011,
    10'b1100001_000, 10'b1010000_101, 10'b1100000_000, 10'b1010000_110,
    10'b1100000_000, 10'b1010000_111,
    10'b0001110_111, 10'b0001110_110, 10'b0001110_101, 10'b0001111_011,
    10'b0001110_010, 10'b0001110_001, 10'b0001110_000, 10'b0000000_000,
    10'b0000000_000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] obs_word();
    return {mem_we, mem_clr, sp_dec, sp_inc, mem_re, rf_we, fetch, rf_rsel | rf_wsel};
  endfunction

  task automatic chk_idle(input string req);
    chk({req, " busy"}, 32'(busy), 32'd0);
    chk({req, " strobes"}, 32'({obs_word(), pc_inc}), 32'd0);
    chk({req, " addr/data"}, 32'(mem_addr) | mem_wdata | rf_wdata, 32'd0);
  endtask

  // Run one burst; raise start again (opposite direction) at tick inj (0 = never).
  task automatic run_burst(input logic p, input logic [15:0] sp, input int inj);
    int          bi  = p ? 14 : 0;
    int          len = p ? 9 : 14;
    logic [9:0]  ev;
    logic [15:0] ea;
    @(negedge clk);
    start_i = 1'b1; pop_i = p; sp_i = sp;
    for (int t = 1; t <= len; t++) begin
      @(negedge clk);
      start_i = (t == inj);
      pop_i   = ~p;
      sp_i    = sp ^ 16'h5A5A;                        // R9: must not matter
      ev = VEC[bi + t - 1];
      chk(p ? "R7 R8 restore strobes" : "R3 R4 R5 save strobes", 32'(obs_word()), 32'(ev));
      chk("R6 pc_inc with fetch", 32'(pc_inc), 32'(ev[3]));
      chk("R2 busy in burst", 32'(busy), 32'd1);
      if (!p) begin
        ea = sp - 16'((t + 1) / 2);
        chk("R5 R9 save address", 32'(mem_addr), 32'(ea));
        chk("R3 R4 save write data", mem_wdata,
            (t % 2 == 0) ? {8'hA5, 21'h0, ev[2:0]} : 32'd0);
      end else begin
        ea = (t <= 7) ? sp + 16'(t - 1) : 16'h0;
        chk("R7 R9 restore address", 32'(mem_addr), 32'(ea));
        chk("R7 restore write-back data", rf_wdata, (t <= 7) ? {16'hC0DE, ea} : 32'd0);
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    chk_idle("R2 R8 after burst");
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; pop_i = 1'b0; sp_i = 16'h0;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after release");

    run_burst(1'b0, 16'h0100, 5);    // save, stray start mid-burst
    run_burst(1'b1, 16'h00F9, 0);    // restore of the same frame
    run_burst(1'b0, 16'h0003, 14);   // save wrapping below zero, start on last tick
    run_burst(1'b1, 16'hFFFC, 9);    // restore wrapping past top, start on last tick
    run_burst(1'b1, 16'h1234, 2);    // restore, stray start early

    // R10: reset in the middle of a save burst
    @(negedge clk);
    start_i = 1'b1; pop_i = 1'b0; sp_i = 16'h0200;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk_idle("R10 reset mid-burst");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R10 idle after release");
    run_burst(1'b0, 16'h0200, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule